// File: doc/BRIEF.md
# Multi-Processor Address Frame Filter

This block sits between a serial receiver's deframer and its receive buffer. Each time the deframer completes a character, the block decides whether to write it into the buffer. In multi-processor operation, a station listens only for address characters until software recognises its own address. The block makes this possible by dropping every data character while the filter mode is on.

Whether a character is an address or data depends on the configured character length. For 5 to 8 data bits, the first stop bit marks the type. For 9 data bits, the ninth received bit marks it. A marker of one means address and zero means data. With the filter mode off, every character is written.

The write strobe and data are registered. A dropped character produces no strobe, so the buffer's receive-complete and overrun state never sees it.

Top module: `mp_addr_filter`

## Requirements
- R1: While `mp_en_i` is 0 at the frame-done cycle, every completed character produces exactly one `wr_stb_o` pulse one clock later, with `wr_data_o` equal to the unchanged `frm_data_i`.
- R2: When `chr_sel_i` is 3'b100 (9 data bits) and `mp_en_i` is 1, the character is written if and only if `frm_data_i[8]` is 1. `frm_stop_i` has no effect.
- R3: When `chr_sel_i` is any other code (3'b000..3'b011 select 5..8 data bits; 3'b101..3'b111 are reserved and behave the same way) and `mp_en_i` is 1, the character is written if and only if `frm_stop_i` is 1. `frm_data_i[8]` has no effect.
- R4: A dropped character raises no strobe, and `wr_data_o` keeps the value of the last written character.
- R5: `mp_en_i` is sampled only in the cycle where `frm_done_i` is high. Values it takes in other cycles do not affect the decision.
- R6: While `rst_n` is low at a clock edge, `wr_stb_o` and `wr_data_o` are cleared to zero.
- R7: `wr_stb_o` is never high unless `frm_done_i` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_done_i | input | 1 | One-cycle pulse: a character has been deframed |
| frm_data_i | input | 9 | Received data bits; bit 8 is the ninth bit |
| frm_stop_i | input | 1 | Value of the first stop bit |
| chr_sel_i | input | 3 | Character length code (see R2, R3) |
| mp_en_i | input | 1 | Multi-processor filter mode |
| wr_stb_o | output | 1 | Qualified write strobe to the receive buffer |
| wr_data_o | output | 9 | Character data to the receive buffer |

## Verification
Each decision lands exactly one clock after the frame-done cycle, because one register stage sits between input and output. The driver applies a character on a falling edge. If the character should pass, the driver queues its data. The monitor compares the queue against every strobe seen on the next falling edge.

For characters that should be dropped, the driver checks on that same following falling edge that no strobe appeared and that the data held its last value. The sampling-window case (R5) changes `mp_en_i` only in the cycles around a frame-done pulse and checks the result at that same edge.

// File: rtl/mpf_pkg.sv
// Package: shared constants and types for the multi-processor address filter.
// Assumes a 3-bit character length code; only one code selects nine data bits.
package mpf_pkg;

    localparam int DATA_W = 9;
    localparam int CHR_W  = 3;

    // Character length codes seen by the filter
    typedef enum logic [CHR_W-1:0] {
        CHR_5BIT = 3'b000,
        CHR_6BIT = 3'b001,
        CHR_7BIT = 3'b010,
        CHR_8BIT = 3'b011,
        CHR_9BIT = 3'b100
    } chr_len_e;

    // Decision passed from the type decoder to the write gate
    typedef struct packed {
        logic is_addr;
        logic nine_bit;
    } frm_kind_t;

endpackage

// File: rtl/mpf_type_sel.sv
// Module: mpf_type_sel
// Decides whether a completed character is an address or data character.
// The marker is the ninth data bit in 9-bit mode and the first stop bit otherwise.
// Assumes reserved length codes behave like the 5..8 bit codes.
// NINE_EN = 0 builds a variant without the 9-bit path (stop bit always decides).
module mpf_type_sel
    import mpf_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter bit NINE_EN = 1'b1
) (
    input  logic [W-1:0]     data_i,
    input  logic             stop_i,
    input  logic [CHR_W-1:0] chr_i,
    output frm_kind_t        kind_o
);

    localparam int MARK_IDX = W - 1;

    generate
        if (NINE_EN) begin : g_nine
            // Select the type marker according to the configured length
            always_comb begin
                kind_o.nine_bit = (chr_i == CHR_9BIT);
                kind_o.is_addr  = kind_o.nine_bit ? data_i[MARK_IDX] : stop_i;
            end
        end else begin : g_stop_only
            // Only 5..8 bit characters exist: stop bit is the marker
            always_comb begin
                kind_o.nine_bit = 1'b0;
                kind_o.is_addr  = stop_i;
            end
        end
    endgenerate

endmodule

// File: rtl/mpf_gate.sv
// Module: mpf_gate
// Qualifies the buffer write: passes every character when the filter is off,
// only address characters when it is on. Registers strobe and data.
// Assumes done_i is a single-cycle pulse per character.
module mpf_gate
    import mpf_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done_i,
    input  logic [W-1:0] data_i,
    input  logic         filt_i,
    input  frm_kind_t    kind_i,
    output logic         stb_o,
    output logic [W-1:0] data_o
);

    logic pass;

    // Write decision at the frame-done cycle
    always_comb begin
        pass = done_i && (!filt_i || kind_i.is_addr);
    end

    // Register strobe; load data only for written characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o  <= 1'b0;
            data_o <= '0;
        end else begin
            stb_o <= pass;
            if (pass) begin
                data_o <= data_i;
            end
        end
    end

    AST_DROP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && filt_i && !kind_i.is_addr |=> !stb_o); // R4
    AST_PASS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !filt_i |=> stb_o && data_o == $past(data_i)); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !stb_o); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_o |-> $stable(data_o)); // R4

endmodule

// File: rtl/mp_addr_filter.sv
// Module: mp_addr_filter (top)
// Sits between the deframer and the receive buffer and drops data characters
// while multi-processor mode is on. One clock of latency from frame done to strobe.
// Assumes the deframer presents data, stop bit and done in the same cycle.
module mp_addr_filter
    import mpf_pkg::*;
#(
    parameter int W       = DATA_W,
    parameter bit NINE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_done_i,
    input  logic [W-1:0]     frm_data_i,
    input  logic             frm_stop_i,
    input  logic [CHR_W-1:0] chr_sel_i,
    input  logic             mp_en_i,
    output logic             wr_stb_o,
    output logic [W-1:0]     wr_data_o
);

    localparam int MARK_IDX = W - 1;

    frm_kind_t kind;

    mpf_type_sel #(.W(W), .NINE_EN(NINE_EN)) type_i (
        .data_i (frm_data_i),
        .stop_i (frm_stop_i),
        .chr_i  (chr_sel_i),
        .kind_o (kind)
    );

    mpf_gate #(.W(W)) gate_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (frm_done_i),
        .data_i (frm_data_i),
        .filt_i (mp_en_i),
        .kind_i (kind),
        .stb_o  (wr_stb_o),
        .data_o (wr_data_o)
    );

    AST_NINE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done_i && mp_en_i && chr_sel_i == CHR_9BIT
        |=> wr_stb_o == $past(frm_data_i[MARK_IDX])); // R2
    AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done_i && mp_en_i && chr_sel_i != CHR_9BIT
        |=> wr_stb_o == $past(frm_stop_i)); // R3
    AST_RESET_CLR: assert property (@(posedge clk)
        !rst_n |=> !wr_stb_o && wr_data_o == '0); // R6

endmodule

// File: tb/mp_addr_filter_tb.sv
// Scoreboard bench: driver queues expected writes, monitor pops them on strobes.
module mp_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_done_i = 1'b0;
    logic [8:0] frm_data_i = '0;
    logic       frm_stop_i = 1'b0;
    logic [2:0] chr_sel_i = '0;
    logic       mp_en_i = 1'b0;
    logic       wr_stb_o;
    logic [8:0] wr_data_o;

    typedef struct {
        logic [8:0] d;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails = 0;
    logic [8:0] last_wr = '0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mp_addr_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_done_i (frm_done_i),
        .frm_data_i (frm_data_i),
        .frm_stop_i (frm_stop_i),
        .chr_sel_i  (chr_sel_i),
        .mp_en_i    (mp_en_i),
        .wr_stb_o   (wr_stb_o),
        .wr_data_o  (wr_data_o)
    );

    // Model of the write decision, taken from R1..R3
    function automatic bit exp_pass(logic [8:0] d, logic st, logic [2:0] c, logic mp);
        logic mark;
        mark = (c == 3'b100) ? d[8] : st;
        return !mp || mark;
    endfunction

    // Monitor: every strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished && wr_stb_o) begin
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected strobe: actual data %h, expected no write", wr_data_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (wr_data_o !== e.d) begin
                    fails++;
                    $display("FAIL %s write data: actual %h expected %h", e.tag, wr_data_o, e.d);
                end
            end
        end
    end

    // Driver: one character, then check drops on the following falling edge
    task automatic send(logic [8:0] d, logic st, logic [2:0] c, logic mp, string tag);
        bit p;
        @(negedge clk);
        frm_data_i = d; frm_stop_i = st; chr_sel_i = c; mp_en_i = mp;
        frm_done_i = 1'b1;
        p = exp_pass(d, st, c, mp);
        if (p) begin
            sb_q.push_back('{d: d, tag: tag});
            last_wr = d;
        end
        @(negedge clk);
        frm_done_i = 1'b0;
        if (!p) begin
            checks++;
            if (wr_stb_o !== 1'b0 || wr_data_o !== last_wr) begin
                fails++;
                $display("FAIL %s dropped frame: actual stb %b data %h expected stb 0 data %h",
                         tag, wr_stb_o, wr_data_o, last_wr);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R6: reset state
        checks++;
        if (wr_stb_o !== 1'b0 || wr_data_o !== 9'h000) begin
            fails++;
            $display("FAIL R6 reset: actual stb %b data %h expected 0 000", wr_stb_o, wr_data_o);
        end
        rst_n = 1'b1;

        // R1: filter off, all lengths and stop values pass unchanged
        send(9'h0A5, 1'b0, 3'b000, 1'b0, "R1");
        send(9'h15A, 1'b1, 3'b011, 1'b0, "R1");
        send(9'h0FF, 1'b0, 3'b100, 1'b0, "R1");
        send(9'h000, 1'b0, 3'b010, 1'b0, "R1");

        // R3: 5..8 bit lengths, stop bit decides, ninth bit ignored
        for (int c = 0; c < 4; c++) begin
            send(9'h033 + 9'(c), 1'b1, 3'(c), 1'b1, "R3");
            send(9'h1C0 + 9'(c), 1'b0, 3'(c), 1'b1, "R3");
        end
        // R3: reserved codes follow the stop bit
        for (int c = 5; c < 8; c++) begin
            send(9'h0E0 + 9'(c), 1'b1, 3'(c), 1'b1, "R3");
            send(9'h1E0 + 9'(c), 1'b0, 3'(c), 1'b1, "R3");
        end

        // R2: 9-bit length, ninth bit decides, stop bit ignored
        send(9'h142, 1'b0, 3'b100, 1'b1, "R2");
        send(9'h042, 1'b1, 3'b100, 1'b1, "R2");
        send(9'h1FF, 1'b1, 3'b100, 1'b1, "R2");
        send(9'h0FF, 1'b0, 3'b100, 1'b1, "R2");

        // R4: back-to-back drops hold the last written data
        send(9'h077, 1'b0, 3'b011, 1'b1, "R4");
        send(9'h0AA, 1'b0, 3'b011, 1'b1, "R4");

        // R5: mode high around the frame, low only at done -> written
        @(negedge clk);
        mp_en_i = 1'b1;
        @(negedge clk);
        frm_data_i = 9'h05C; frm_stop_i = 1'b0; chr_sel_i = 3'b011;
        mp_en_i = 1'b0; frm_done_i = 1'b1;
        sb_q.push_back('{d: 9'h05C, tag: "R5"});
        last_wr = 9'h05C;
        @(negedge clk);
        frm_done_i = 1'b0; mp_en_i = 1'b1;
        // R5: mode low around the frame, high only at done -> dropped
        @(negedge clk);
        mp_en_i = 1'b0;
        @(negedge clk);
        frm_data_i = 9'h0C3; mp_en_i = 1'b1; frm_done_i = 1'b1;
        @(negedge clk);
        frm_done_i = 1'b0; mp_en_i = 1'b0;
        checks++;
        if (wr_stb_o !== 1'b0 || wr_data_o !== last_wr) begin
            fails++;
            $display("FAIL R5 mode sampled at done: actual stb %b data %h expected 0 %h",
                     wr_stb_o, wr_data_o, last_wr);
        end

        // R7: idle cycles with inputs moving but no done give no strobe
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            frm_data_i = 9'(i * 37); frm_stop_i = i[0];
            checks++;
            if (wr_stb_o !== 1'b0) begin
                fails++;
                $display("FAIL R7 idle strobe: actual %b expected 0", wr_stb_o);
            end
        end

        // R1: every queued write was seen
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing writes: actual %0d pending expected 0", sb_q.size());
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL R7 watchdog: actual still running expected finished");
            summary();
            $finish;
        end
    end

endmodule